// File: doc/BRIEF.md
# Flag Offset Register Sequencer

This block holds the two thresholds used by a FIFO's programmable flag logic: the almost-empty offset and the almost-full offset. Each offset is stored as a pair of registers. One holds the low eight bits and the other holds the remaining upper bits. That gives four small registers, and all of them come out of reset at a configurable default. When the part is in programming mode, a load strobe lets software-style traffic on the FIFO's own data bus write these registers on write-clock edges and read them back on read-clock edges. Both directions walk a fixed four-slot rotation, and each direction has its own position counter. The counters keep their place when the strobe is released, so a partial update resumes at the next register.

The mode is chosen during reset. If the dual-purpose strobe pin is held low while reset is active, the block enters programming mode. If the pin is held high, it acts as a second active-high write enable and the sequencer ignores it. The block also produces the gated FIFO write and read enables, so normal data traffic never moves while an offset access is taking place. A registered select output tells the output multiplexer whether the data bus is carrying offset readback or FIFO data.

Top module: `offset_seq`

## Requirements
- R1: Reset is synchronous and active low, on each clock. During reset both offsets take the value DEF_OFS (7), the readback register clears to 0, qFromOfs clears to 0, and both position counters point at slot 0.
- R2: The level of ldN sampled while reset is active fixes the mode until the next reset. Low selects programming mode. High selects two-enable mode.
- R3: In programming mode, a wrClk edge with ldN=0 and wrEnN=0 stores dataIn into the slot at the write position. Slot 0 is the almost-empty low byte, slot 1 is the almost-empty upper bits, slot 2 is the almost-full low byte and slot 3 is the almost-full upper bits. A low slot keeps dataIn[7:0]. An upper slot keeps dataIn[OFS_W-9:0]. ofsEmpty is {slot1,slot0} and ofsFull is {slot3,slot2}.
- R4: Each offset write advances the write position by one, modulo 4, so the fifth consecutive write lands in slot 0 again.
- R5: A wrClk edge with ldN=0 and wrEnN=1 changes no offset and does not move the write position.
- R6: Raising ldN keeps both positions. The next offset access after ldN falls again goes to the following slot.
- R7: In programming mode, an rdClk edge with ldN=0, rdEnAN=0 and rdEnBN=0 loads the slot at the read position into ofsRdData, zero-extended. The same edge advances the read position modulo 4 in the same slot order and sets qFromOfs to 1.
- R8: fifoWrEn is 1 exactly when rstN=1, wrEnN=0 and ldN=1. fifoRdEn is 1 exactly when rstN=1, rdEnAN=0, rdEnBN=0, and either ldN=1 or the block is in two-enable mode.
- R9: In two-enable mode, ldN=0 blocks FIFO writes and never touches the offsets, the positions, ofsRdData or qFromOfs.
- R10: An rdClk edge with fifoRdEn=1 clears qFromOfs. ofsRdData keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Synchronous active-low reset |
| ldN | input | 1 | Load strobe (programming mode) or second write enable, active high (two-enable mode) |
| wrEnN | input | 1 | Write enable, active low |
| rdEnAN | input | 1 | First read enable, active low |
| rdEnBN | input | 1 | Second read enable, active low |
| dataIn | input | DATA_W | FIFO input data bus, also the offset load data |
| fifoWrEn | output | 1 | Gated FIFO write enable |
| fifoRdEn | output | 1 | Gated FIFO read enable |
| ofsEmpty | output | OFS_W | Almost-empty offset to the flag logic |
| ofsFull | output | OFS_W | Almost-full offset to the flag logic |
| ofsRdData | output | DATA_W | Offset readback word |
| qFromOfs | output | 1 | Output bus carries offset readback rather than FIFO data |

## Verification
The bench builds the block with its defaults: a 9-bit bus, a depth of 16384 and therefore 14-bit offsets with 6-bit upper registers, and a default offset of 7. Because the upper registers are narrower than the bus, loads that put ones in bits 6 to 8 show whether masking is correct. The 9-bit bus also makes zero-extension on readback visible. Both clocks run from one source, which brings write-then-readback sequences, ring wrap in both directions and mode switching through reset within reach of short directed runs and a long random mix.

// File: rtl/ofsseq_pkg.sv
package ofsseq_pkg;

  localparam int unsigned SLOT_NUM = 4;

  // Slot order is behaviour: load and readback both walk it.
  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_t;

  typedef struct packed {
    logic  loadWr;
    logic  loadRd;
    logic  fifoRd;
    slot_t wrPos;
    slot_t rdPos;
  } seqStrobe_t;

endpackage

// File: rtl/ofsseq_ctrl.sv
module ofsseq_ctrl
  import ofsseq_pkg::*;
(
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       ldN,
  input  logic       wrEnN,
  input  logic       rdEnAN,
  input  logic       rdEnBN,
  output seqStrobe_t strb,
  output logic       fifoWrEn,
  output logic       fifoRdEn
);

  logic  progModeW;
  logic  progModeR;
  slot_t wrPos;
  slot_t rdPos;
  logic  loadWr;
  logic  loadRd;

  // Mode is captured separately in each clock domain while reset is held.
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      progModeW <= ~ldN;
      wrPos     <= SLOT_E_LO;
    end else if (loadWr) begin
      wrPos <= slot_t'(wrPos + 2'd1);
    end
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      progModeR <= ~ldN;
      rdPos     <= SLOT_E_LO;
    end else if (loadRd) begin
      rdPos <= slot_t'(rdPos + 2'd1);
    end
  end

  always_comb begin
    loadWr   = rstN && progModeW && !ldN && !wrEnN;
    loadRd   = rstN && progModeR && !ldN && !rdEnAN && !rdEnBN;
    // The pin is the load strobe or the second enable; either way high lets writes through.
    fifoWrEn = rstN && !wrEnN && ldN;
    fifoRdEn = rstN && !rdEnAN && !rdEnBN && (ldN || !progModeR);
  end

  always_comb begin
    strb.loadWr = loadWr;
    strb.loadRd = loadRd;
    strb.fifoRd = fifoRdEn;
    strb.wrPos  = wrPos;
    strb.rdPos  = rdPos;
  end

  p_mode_hold_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> $stable(progModeW));

  p_wpos_wrap_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    loadWr |=> wrPos == slot_t'($past(wrPos) + 2'd1));

  p_wpos_hold_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    !loadWr |=> $stable(wrPos));

  p_rpos_hold_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    !loadRd |=> $stable(rdPos));

  p_wr_excl_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    !(fifoWrEn && loadWr));

  p_rd_excl_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    !(fifoRdEn && loadRd));

endmodule

// File: rtl/ofsseq_regs.sv
module ofsseq_regs
  import ofsseq_pkg::*;
#(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned OFS_W   = 14,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  seqStrobe_t        strb,
  output logic [OFS_W-1:0]  ofsEmpty,
  output logic [OFS_W-1:0]  ofsFull,
  output logic [DATA_W-1:0] ofsRdData,
  output logic              qFromOfs
);

  localparam int unsigned LO_W  = 8;
  localparam int unsigned HI_W  = OFS_W - LO_W;
  localparam int unsigned PAIRS = SLOT_NUM / 2;
  localparam logic [OFS_W-1:0] DEF_VEC = OFS_W'(DEF_OFS);

  logic [PAIRS-1:0][LO_W-1:0] loVec;
  logic [PAIRS-1:0][HI_W-1:0] hiVec;
  logic [DATA_W-1:0]          selWord;

  // One low/high register pair per offset; pair 0 is almost-empty, pair 1 almost-full.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam slot_t LO_SLOT = slot_t'(2 * p);
    localparam slot_t HI_SLOT = slot_t'(2 * p + 1);
    logic [LO_W-1:0] loReg;
    logic [HI_W-1:0] hiReg;

    always_ff @(posedge wrClk) begin
      if (!rstN) begin
        loReg <= DEF_VEC[LO_W-1:0];
        hiReg <= DEF_VEC[OFS_W-1:LO_W];
      end else if (strb.loadWr) begin
        if (strb.wrPos == LO_SLOT) loReg <= dataIn[LO_W-1:0];
        if (strb.wrPos == HI_SLOT) hiReg <= dataIn[HI_W-1:0];
      end
    end

    assign loVec[p] = loReg;
    assign hiVec[p] = hiReg;
  end

  assign ofsEmpty = {hiVec[0], loVec[0]};
  assign ofsFull  = {hiVec[1], loVec[1]};

  always_comb begin
    unique case (strb.rdPos)
      SLOT_E_LO: selWord = DATA_W'(loVec[0]);
      SLOT_E_HI: selWord = DATA_W'(hiVec[0]);
      SLOT_F_LO: selWord = DATA_W'(loVec[1]);
      default:   selWord = DATA_W'(hiVec[1]);
    endcase
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      ofsRdData <= '0;
      qFromOfs  <= 1'b0;
    end else if (strb.loadRd) begin
      ofsRdData <= selWord;
      qFromOfs  <= 1'b1;
    end else if (strb.fifoRd) begin
      qFromOfs  <= 1'b0;
    end
  end

  p_elo_load_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (strb.loadWr && strb.wrPos == SLOT_E_LO) |=> ofsEmpty[LO_W-1:0] == $past(dataIn[LO_W-1:0]));

  p_fhi_load_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (strb.loadWr && strb.wrPos == SLOT_F_HI) |=> ofsFull[OFS_W-1:LO_W] == $past(dataIn[HI_W-1:0]));

  p_ofs_hold_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    !strb.loadWr |=> ($stable(ofsEmpty) && $stable(ofsFull)));

  p_qsel_set_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    strb.loadRd |=> qFromOfs);

  p_qsel_clr_r10: assert property (@(posedge rdClk) disable iff (!rstN)
    (strb.fifoRd && !strb.loadRd) |=> (!qFromOfs && $stable(ofsRdData)));

endmodule

// File: rtl/offset_seq.sv
module offset_seq
  import ofsseq_pkg::*;
#(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned DEPTH   = 16384,
  parameter int unsigned DEF_OFS = 7,
  localparam int unsigned OFS_W  = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              wrEnN,
  input  logic              rdEnAN,
  input  logic              rdEnBN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              fifoWrEn,
  output logic              fifoRdEn,
  output logic [OFS_W-1:0]  ofsEmpty,
  output logic [OFS_W-1:0]  ofsFull,
  output logic [DATA_W-1:0] ofsRdData,
  output logic              qFromOfs
);

  seqStrobe_t strb;

  ofsseq_ctrl u_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .ldN      (ldN),
    .wrEnN    (wrEnN),
    .rdEnAN   (rdEnAN),
    .rdEnBN   (rdEnBN),
    .strb     (strb),
    .fifoWrEn (fifoWrEn),
    .fifoRdEn (fifoRdEn)
  );

  ofsseq_regs #(
    .DATA_W  (DATA_W),
    .OFS_W   (OFS_W),
    .DEF_OFS (DEF_OFS)
  ) u_regs (
    .wrClk     (wrClk),
    .rdClk     (rdClk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .strb      (strb),
    .ofsEmpty  (ofsEmpty),
    .ofsFull   (ofsFull),
    .ofsRdData (ofsRdData),
    .qFromOfs  (qFromOfs)
  );

endmodule

// File: tb/offset_seq_test.sv
`timescale 1ns/1ps
module offset_seq_test;

  localparam int DW   = 9;
  localparam int OW   = 14;
  localparam int HIW  = OW - 8;

  logic clk = 1'b0;
  logic rstN, ldN, wrEnN, rdEnAN, rdEnBN;
  logic [DW-1:0] dataIn;
  logic fifoWrEn, fifoRdEn, qFromOfs;
  logic [OW-1:0] ofsEmpty, ofsFull;
  logic [DW-1:0] ofsRdData;

  always #2.5 clk = ~clk;

  offset_seq uut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .ldN(ldN), .wrEnN(wrEnN),
    .rdEnAN(rdEnAN), .rdEnBN(rdEnBN), .dataIn(dataIn),
    .fifoWrEn(fifoWrEn), .fifoRdEn(fifoRdEn), .ofsEmpty(ofsEmpty),
    .ofsFull(ofsFull), .ofsRdData(ofsRdData), .qFromOfs(qFromOfs)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mSlot[4];
  int wp, rp, expRd;
  bit pm, expQ;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int maskSlot(int s, int v);
    return (s % 2 == 0) ? (v & 255) : (v & ((1 << HIW) - 1));
  endfunction

  function automatic int expEmpty();
    return (mSlot[1] << 8) | mSlot[0];
  endfunction

  function automatic int expFull();
    return (mSlot[3] << 8) | mSlot[2];
  endfunction

  task automatic doReset(bit ldAtReset);
    @(negedge clk);
    rstN = 0; ldN = ldAtReset; wrEnN = 1; rdEnAN = 1; rdEnBN = 1; dataIn = '0;
    @(negedge clk);
    @(negedge clk);
    mSlot = '{7, 0, 7, 0};
    wp = 0; rp = 0; expRd = 0; expQ = 0; pm = !ldAtReset;
    rstN = 1; ldN = 1;
    #1;
  endtask

  // One clock: check state left by the last edge, drive, check gating, advance model.
  task automatic cyc(bit ld, bit we, bit ra, bit rb, int d);
    bit ew, er, lw, lr;
    @(negedge clk);
    check("R3 ofsEmpty", int'(ofsEmpty), expEmpty());
    check("R3 ofsFull", int'(ofsFull), expFull());
    check("R7 ofsRdData", int'(ofsRdData), expRd);
    check("R10 qFromOfs", int'(qFromOfs), int'(expQ));
    ldN = ld; wrEnN = we; rdEnAN = ra; rdEnBN = rb; dataIn = DW'(d);
    #1;
    ew = !we && ld;
    er = !ra && !rb && (ld || !pm);
    check("R8 fifoWrEn", int'(fifoWrEn), int'(ew));
    check("R8 fifoRdEn", int'(fifoRdEn), int'(er));
    lw = pm && !ld && !we;
    lr = pm && !ld && !ra && !rb;
    if (lr) begin
      expRd = mSlot[rp]; rp = (rp + 1) % 4; expQ = 1;
    end else if (er) expQ = 0;
    if (lw) begin
      mSlot[wp] = maskSlot(wp, d); wp = (wp + 1) % 4;
    end
  endtask

  task automatic idle();
    cyc(1, 1, 1, 1, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rdExp[5];
    void'($urandom(32'd1234));
    rstN = 0; ldN = 0; wrEnN = 1; rdEnAN = 1; rdEnBN = 1; dataIn = '0;

    // R1 reset defaults in programming mode
    doReset(0);
    check("R1 ofsEmpty default", int'(ofsEmpty), 7);
    check("R1 ofsFull default", int'(ofsFull), 7);
    check("R1 qFromOfs reset", int'(qFromOfs), 0);
    check("R1 ofsRdData reset", int'(ofsRdData), 0);
    cyc(0, 1, 0, 0, 0); idle();
    check("R1 readback slot0", int'(ofsRdData), 7);
    cyc(0, 1, 0, 0, 0); idle();
    check("R1 readback slot1", int'(ofsRdData), 0);
    cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0); idle(); // realign read position to slot 0

    // R3 full rotation with masking of upper bits
    cyc(0, 0, 1, 1, 'h1A5);
    cyc(0, 0, 1, 1, 'h1FF);
    cyc(0, 0, 1, 1, 'h033);
    cyc(0, 0, 1, 1, 'h0C1);
    idle();
    check("R3 ofsEmpty after four loads", int'(ofsEmpty), 'h3FA5);
    check("R3 ofsFull after four loads", int'(ofsFull), 'h0133);
    // R4 fifth write wraps to slot 0
    cyc(0, 0, 1, 1, 'h011); idle();
    check("R4 wrap to empty low", int'(ofsEmpty), 'h3F11);
    // R5 strobe low with write enable high does nothing
    cyc(0, 1, 1, 1, 'h0EE); cyc(0, 1, 1, 1, 'h0EE); cyc(0, 1, 1, 1, 'h0EE); idle();
    check("R5 no-op keeps empty", int'(ofsEmpty), 'h3F11);
    check("R5 no-op keeps full", int'(ofsFull), 'h0133);
    cyc(0, 0, 1, 1, 'h005); idle();
    check("R5 position unmoved", int'(ofsEmpty), 'h0511);
    // R6 session break with a FIFO write between
    cyc(1, 0, 1, 1, 'h1FF);
    check("R8 FIFO write with strobe high", int'(fifoWrEn), 1);
    cyc(0, 0, 1, 1, 'h044); idle();
    check("R6 resumes at full low", int'(ofsFull), 'h0144);
    check("R6 empty untouched", int'(ofsEmpty), 'h0511);

    // R7 readback rotation and wrap
    rdExp = '{'h11, 'h05, 'h44, 'h01, 'h11};
    foreach (rdExp[k]) begin
      cyc(0, 1, 0, 0, 0);
      check("R8 no FIFO read while loading", int'(fifoRdEn), 0);
      idle();
      check("R7 readback word", int'(ofsRdData), rdExp[k]);
    end
    check("R7 qFromOfs set", int'(qFromOfs), 1);
    // R10 FIFO read clears the select
    cyc(1, 1, 0, 0, 0); idle();
    check("R10 qFromOfs cleared", int'(qFromOfs), 0);
    check("R10 readback word held", int'(ofsRdData), 'h11);

    // R2 / R9 two-enable mode
    doReset(1);
    check("R1 default after reset", int'(ofsEmpty), 7);
    cyc(0, 0, 1, 1, 'h0AA);
    check("R9 second enable low blocks write", int'(fifoWrEn), 0);
    idle();
    check("R9 offsets untouched", int'(ofsEmpty), 7);
    cyc(0, 1, 0, 0, 0);
    check("R2 read with pin low is FIFO read", int'(fifoRdEn), 1);
    idle();
    check("R9 no readback select", int'(qFromOfs), 0);
    check("R9 readback word untouched", int'(ofsRdData), 0);

    // Random mix with mode changes through reset
    doReset(0);
    for (int i = 0; i < 3000; i++) begin
      bit ld, we, ra, rb;
      if (i % 700 == 699) doReset(bit'($urandom_range(0, 3) == 0));
      ld = ($urandom_range(0, 2) == 0);
      we = $urandom_range(0, 1);
      ra = ($urandom_range(0, 3) == 0);
      rb = ($urandom_range(0, 3) == 0);
      if (pm && !ld && !we && !ra && !rb) ra = 1;
      cyc(ld, we, ra, rb, int'($urandom_range(0, 511)));
    end
    idle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule